// File: doc/BRIEF.md
# Set-Clear-Toggle Control Register Bank

This block is a bank of 32-bit control registers behind a simple request/response bus slave. Every register owns a 16-byte address slot, and the two address bits just above the word offset choose how a write is applied: a plain replace, a bitwise OR, a bitwise clear, or a bitwise XOR. This lets software change a few bits of a control word without reading it first. Reads at any of a slot's four addresses return the stored word.

The bank has two register groups at parameterised base addresses (a primary group, 0x060 by default, and a secondary group, 0x200 by default) and one read-only identification word at 0x800. The identification word wins over any group slot that overlaps it. Each register has its own reset value set by a parameter. In primary-group registers picked by a mask, reset also forces a lock status bit to 1. Accesses outside every window, misaligned accesses and writes to the identification word are ignored and flagged with an error strobe.

Top module: `sct_reg_bank`

## Requirements
- R1: After reset, primary register i reads MAIN_RST[i], with bit LOCK_BIT also set when LOCK_MASK[i] is 1. Secondary register j reads AUX_RST[j], and the identification word at 0x800 reads ID_WORD (default 0x00720010).
- R2: A write at slot address + 0x0 (address bits [3:2] = 0) replaces the register with the write data.
- R3: A write at slot address + 0x4 (bits [3:2] = 1) ORs the write data into the register.
- R4: A write at slot address + 0x8 (bits [3:2] = 2) clears every register bit that is 1 in the write data.
- R5: A write at slot address + 0xC (bits [3:2] = 3) XORs the write data into the register.
- R6: A read at any of a slot's four aligned addresses returns the stored word with busErr low, and it leaves the register unchanged.
- R7: busReady is high in exactly the cycle after each request, and busRdata and busErr are valid in that cycle. A write changes the register at the edge that accepts it, so a read issued in the next cycle returns the new value. A write's response data is zero.
- R8: A write to the identification word is ignored and answered with busErr high. A read of it returns ID_WORD with busErr low.
- R9: When a group slot overlaps address 0x800, a read of 0x800 returns ID_WORD and a write there is rejected. The slot's other three addresses (0x804, 0x808, 0x80C) still reach the register.
- R10: A request to an address outside every window returns zero data with busErr high, and a write there changes no register.
- R11: A request whose address bits [1:0] are not zero is ignored and returns zero data with busErr high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busReq | input | 1 | Request strobe, one access per cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W | Byte address |
| busWdata | input | 32 | Write data |
| busReady | output | 1 | Response valid, the cycle after the request |
| busRdata | output | 32 | Read data, zero for writes and errors |
| busErr | output | 1 | Access rejected |

## Verification
The hardest case to reach from the ports is the identification word shadowing part of a register slot. With the default layout the identification word overlaps nothing. The bench therefore places the secondary group across 0x800, so one slot loses its plain-write address and can still be reached through its OR, clear and XOR addresses. The bench then sweeps every slot, every operation and several data patterns against an arithmetic model. After each out-of-window and misaligned write, it rereads every register to confirm nothing changed.

// File: rtl/sct_bank_pkg.sv
package sct_bank_pkg;
  localparam int SLOT_IDX_W = 8;

  typedef enum logic [1:0] {
    OP_WRITE = 2'd0,
    OP_SET   = 2'd1,
    OP_CLEAR = 2'd2,
    OP_FLIP  = 2'd3
  } sctOp_e;

  typedef struct packed {
    logic                  wrMain;
    logic                  wrAux;
    logic                  rdMain;
    logic                  rdAux;
    logic                  rdId;
    logic                  err;
    sctOp_e                op;
    logic [SLOT_IDX_W-1:0] idx;
  } sctStrb_t;

  function automatic logic [31:0] applyOp(sctOp_e op, logic [31:0] cur, logic [31:0] wd);
    logic [31:0] res;
    case (op)
      OP_WRITE: res = wd;
      OP_SET:   res = cur | wd;
      OP_CLEAR: res = cur & ~wd;
      default:  res = cur ^ wd;
    endcase
    return res;
  endfunction
endpackage

// File: rtl/sct_ctrl.sv
module sct_ctrl
  import sct_bank_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int N_MAIN    = 8,
  parameter int N_AUX     = 4,
  parameter int MAIN_BASE = 'h060,
  parameter int AUX_BASE  = 'h200,
  parameter int ID_ADDR   = 'h800
) (
  input  logic              busReq,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  output sctStrb_t          strb
);
  localparam logic [ADDR_W-1:0] MAIN_LO = ADDR_W'(MAIN_BASE);
  localparam logic [ADDR_W-1:0] MAIN_HI = ADDR_W'(MAIN_BASE + N_MAIN * 16);
  localparam logic [ADDR_W-1:0] AUX_LO  = ADDR_W'(AUX_BASE);
  localparam logic [ADDR_W-1:0] AUX_HI  = ADDR_W'(AUX_BASE + N_AUX * 16);
  localparam logic [ADDR_W-1:0] ID_A    = ADDR_W'(ID_ADDR);

  logic aligned, idHit, mainHit, auxHit;
  logic [ADDR_W-1:0] mainOff, auxOff;

  assign aligned = (busAddr[1:0] == 2'b00);
  assign idHit   = (busAddr == ID_A);
  assign mainHit = (busAddr >= MAIN_LO) && (busAddr < MAIN_HI);
  assign auxHit  = (busAddr >= AUX_LO) && (busAddr < AUX_HI);
  assign mainOff = busAddr - MAIN_LO;
  assign auxOff  = busAddr - AUX_LO;

  always_comb begin
    strb = '0;
    strb.op = sctOp_e'(busAddr[3:2]);
    if (busReq) begin
      if (!aligned) begin
        strb.err = 1'b1;
      end else if (idHit) begin
        if (busWrite) strb.err = 1'b1;
        else          strb.rdId = 1'b1;
      end else if (mainHit) begin
        strb.idx = SLOT_IDX_W'(mainOff >> 4);
        if (busWrite) strb.wrMain = 1'b1;
        else          strb.rdMain = 1'b1;
      end else if (auxHit) begin
        strb.idx = SLOT_IDX_W'(auxOff >> 4);
        if (busWrite) strb.wrAux = 1'b1;
        else          strb.rdAux = 1'b1;
      end else begin
        strb.err = 1'b1;
      end
    end
  end
endmodule

// File: rtl/sct_datapath.sv
module sct_datapath
  import sct_bank_pkg::*;
#(
  parameter int                     N_MAIN    = 8,
  parameter int                     N_AUX     = 4,
  parameter int                     LOCK_BIT  = 31,
  parameter logic [N_MAIN-1:0]      LOCK_MASK = '1,
  parameter logic [N_MAIN-1:0][31:0] MAIN_RST = '0,
  parameter logic [N_AUX-1:0][31:0]  AUX_RST  = '0,
  parameter logic [31:0]            ID_WORD   = 32'h0072_0010
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        busReq,
  input  logic [31:0] busWdata,
  input  sctStrb_t    strb,
  output logic        busReady,
  output logic [31:0] busRdata,
  output logic        busErr
);
  localparam int MIDX_W = (N_MAIN > 1) ? $clog2(N_MAIN) : 1;
  localparam int AIDX_W = (N_AUX > 1) ? $clog2(N_AUX) : 1;
  localparam logic [31:0] LOCK_VAL = 32'(1) << LOCK_BIT;

  logic [31:0] mainQ [N_MAIN];
  logic [31:0] auxQ  [N_AUX];
  logic [MIDX_W-1:0] mIdx;
  logic [AIDX_W-1:0] aIdx;
  logic [31:0] rdVal;

  assign mIdx = MIDX_W'(strb.idx);
  assign aIdx = AIDX_W'(strb.idx);

  for (genvar i = 0; i < N_MAIN; i++) begin : g_main
    localparam logic [31:0] RV = MAIN_RST[i] | (LOCK_MASK[i] ? LOCK_VAL : 32'h0);
    always_ff @(posedge clk) begin
      if (!rstN)
        mainQ[i] <= RV;
      else if (strb.wrMain && (mIdx == MIDX_W'(i)))
        mainQ[i] <= applyOp(strb.op, mainQ[i], busWdata);
    end
  end

  for (genvar j = 0; j < N_AUX; j++) begin : g_aux
    always_ff @(posedge clk) begin
      if (!rstN)
        auxQ[j] <= AUX_RST[j];
      else if (strb.wrAux && (aIdx == AIDX_W'(j)))
        auxQ[j] <= applyOp(strb.op, auxQ[j], busWdata);
    end
  end

  always_comb begin
    rdVal = '0;
    if (strb.rdId)        rdVal = ID_WORD;
    else if (strb.rdMain) rdVal = mainQ[mIdx];
    else if (strb.rdAux)  rdVal = auxQ[aIdx];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busReady <= 1'b0;
      busRdata <= '0;
      busErr   <= 1'b0;
    end else begin
      busReady <= busReq;
      busRdata <= rdVal;
      busErr   <= strb.err;
    end
  end
endmodule

// File: rtl/sct_reg_bank.sv
module sct_reg_bank
  import sct_bank_pkg::*;
#(
  parameter int                      ADDR_W    = 12,
  parameter int                      N_MAIN    = 8,
  parameter int                      N_AUX     = 4,
  parameter int                      MAIN_BASE = 'h060,
  parameter int                      AUX_BASE  = 'h200,
  parameter int                      ID_ADDR   = 'h800,
  parameter int                      LOCK_BIT  = 31,
  parameter logic [N_MAIN-1:0]       LOCK_MASK = 8'b0011_1111,
  parameter logic [N_MAIN-1:0][31:0] MAIN_RST  = {32'h0, 32'h0, 32'h0000_1f80, 32'h0002_2018,
                                                  32'h0001_1020, 32'h5a5a_2a10, 32'h0040_202c,
                                                  32'h0000_2041},
  parameter logic [N_AUX-1:0][31:0]  AUX_RST   = '0,
  parameter logic [31:0]             ID_WORD   = 32'h0072_0010
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busReq,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output logic              busReady,
  output logic [31:0]       busRdata,
  output logic              busErr
);
  sctStrb_t strb;

  sct_ctrl #(
    .ADDR_W(ADDR_W), .N_MAIN(N_MAIN), .N_AUX(N_AUX),
    .MAIN_BASE(MAIN_BASE), .AUX_BASE(AUX_BASE), .ID_ADDR(ID_ADDR)
  ) u_ctrl (
    .busReq(busReq), .busWrite(busWrite), .busAddr(busAddr), .strb(strb)
  );

  sct_datapath #(
    .N_MAIN(N_MAIN), .N_AUX(N_AUX), .LOCK_BIT(LOCK_BIT), .LOCK_MASK(LOCK_MASK),
    .MAIN_RST(MAIN_RST), .AUX_RST(AUX_RST), .ID_WORD(ID_WORD)
  ) u_dp (
    .clk(clk), .rstN(rstN), .busReq(busReq), .busWdata(busWdata), .strb(strb),
    .busReady(busReady), .busRdata(busRdata), .busErr(busErr)
  );
endmodule

// File: rtl/sct_reg_bank_chk.sv
module sct_reg_bank_chk #(
  parameter int          ADDR_W  = 12,
  parameter int          ID_ADDR = 'h800,
  parameter logic [31:0] ID_WORD = 32'h0072_0010
) (
  input logic              clk,
  input logic              rstN,
  input logic              busReq,
  input logic              busWrite,
  input logic [ADDR_W-1:0] busAddr,
  input logic [31:0]       busWdata,
  input logic              busReady,
  input logic [31:0]       busRdata,
  input logic              busErr
);
  localparam logic [ADDR_W-1:0] ID_A = ADDR_W'(ID_ADDR);

  p_ready_follows_req_r7: assert property (@(posedge clk) disable iff (!rstN)
    busReq |=> busReady);
  p_no_spurious_ready_r7: assert property (@(posedge clk) disable iff (!rstN)
    !busReq |=> !busReady);
  p_write_data_zero_r7: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && busWrite) |=> (busRdata == 32'h0));
  p_id_read_r8: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && !busWrite && busAddr == ID_A) |=> (busRdata == ID_WORD && !busErr));
  p_id_write_err_r8: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && busWrite && busAddr == ID_A) |=> busErr);
  p_err_zero_data_r10: assert property (@(posedge clk) disable iff (!rstN)
    busErr |-> (busRdata == 32'h0 && busReady));
  p_misaligned_err_r11: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && busAddr[1:0] != 2'b00) |=> (busErr && busRdata == 32'h0));
endmodule

bind sct_reg_bank sct_reg_bank_chk #(
  .ADDR_W(ADDR_W), .ID_ADDR(ID_ADDR), .ID_WORD(ID_WORD)
) u_chk (.*);

// File: tb/tb_sct_reg_bank.sv
`timescale 1ns/1ps
module tb_sct_reg_bank;
  localparam int AW = 12;
  localparam int NM = 4;
  localparam int NA = 4;
  localparam int MB = 'h060;
  localparam int AB = 'h7E0;   // secondary group spans 0x7E0..0x81F, across the ID word
  localparam int IDA = 'h800;
  localparam logic [31:0] IDW = 32'h0072_0010;
  localparam logic [NM-1:0] LM = 4'b0101;
  localparam logic [NM-1:0][31:0] MR = {32'h0000_1f80, 32'h0040_202c, 32'h1234_0000, 32'h0000_2041};
  localparam logic [NA-1:0][31:0] AR = {32'hcafe_0003, 32'h0000_0000, 32'h8000_0001, 32'h00ff_00ff};

  logic clk = 1'b0, rstN = 1'b0;
  logic busReq = 1'b0, busWrite = 1'b0;
  logic [AW-1:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic busReady, busErr;
  logic [31:0] busRdata;

  int nChk = 0, nBad = 0;
  logic [31:0] expMain [NM];
  logic [31:0] expAux  [NA];

  always #4 clk = ~clk;

  sct_reg_bank #(
    .ADDR_W(AW), .N_MAIN(NM), .N_AUX(NA), .MAIN_BASE(MB), .AUX_BASE(AB),
    .ID_ADDR(IDA), .LOCK_BIT(31), .LOCK_MASK(LM), .MAIN_RST(MR), .AUX_RST(AR), .ID_WORD(IDW)
  ) dut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // Model of one access: returns expected data/err and applies writes to the model.
  task automatic model(input logic w, input logic [AW-1:0] a, input logic [31:0] d,
                       output logic [31:0] eD, output logic eE);
    int ia = int'(a);
    logic [31:0] cur;
    int k;
    eD = '0; eE = 1'b0;
    if (a[1:0] != 2'b00) eE = 1'b1;
    else if (ia == IDA) begin
      if (w) eE = 1'b1; else eD = IDW;
    end else if (ia >= MB && ia < MB + NM*16) begin
      k = (ia - MB) / 16;
      cur = expMain[k];
      if (!w) eD = cur;
      else case (a[3:2])
        2'd0: expMain[k] = d;
        2'd1: expMain[k] = cur | d;
        2'd2: expMain[k] = cur & ~d;
        default: expMain[k] = cur ^ d;
      endcase
    end else if (ia >= AB && ia < AB + NA*16) begin
      k = (ia - AB) / 16;
      cur = expAux[k];
      if (!w) eD = cur;
      else case (a[3:2])
        2'd0: expAux[k] = d;
        2'd1: expAux[k] = cur | d;
        2'd2: expAux[k] = cur & ~d;
        default: expAux[k] = cur ^ d;
      endcase
    end else eE = 1'b1;
  endtask

  task automatic xfer(input string tag, input logic w, input logic [AW-1:0] a, input logic [31:0] d);
    logic [31:0] eD;
    logic eE;
    model(w, a, d, eD, eE);
    @(negedge clk);
    busReq = 1'b1; busWrite = w; busAddr = a; busWdata = d;
    @(negedge clk);
    busReq = 1'b0; busWrite = 1'b0;
    chk({tag, " R7 ready"}, {31'h0, busReady}, 32'h1);
    chk({tag, " data"}, busRdata, eD);
    chk({tag, " err"}, {31'h0, busErr}, {31'h0, eE});
  endtask

  task automatic readAllSlots(input string tag);
    for (int i = 0; i < NM; i++)
      for (int o = 0; o < 4; o++) xfer(tag, 1'b0, AW'(MB + 16*i + 4*o), '0);
    for (int i = 0; i < NA; i++)
      for (int o = 0; o < 4; o++) xfer(tag, 1'b0, AW'(AB + 16*i + 4*o), '0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog act=%h exp=%h", 32'h1, 32'h0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    for (int i = 0; i < NM; i++) expMain[i] = MR[i] | (LM[i] ? 32'h8000_0000 : 32'h0);
    for (int i = 0; i < NA; i++) expAux[i] = AR[i];
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    chk("R7 idle ready", {31'h0, busReady}, 32'h0);

    // R1 / R10 / R8: reset state across the whole aligned address space
    for (int a = 0; a < (1 << AW); a += 4) xfer("R1 R10 reset sweep", 1'b0, AW'(a), '0);

    // R2..R5 and R6: every slot, every operation, several patterns
    for (int p = 0; p < 3; p++)
      for (int g = 0; g < 2; g++)
        for (int i = 0; i < 4; i++)
          for (int op = 0; op < 4; op++) begin
            logic [31:0] d;
            int base;
            base = (g == 0) ? MB : AB;
            d = (32'h9c3e_51a7 * (p + 1)) ^ (32'h0101_0101 * (i + 1)) ^ (32'hf << (op * 8));
            case (op)
              0: xfer("R2 write", 1'b1, AW'(base + 16*i), d);
              1: xfer("R3 set", 1'b1, AW'(base + 16*i + 4), d);
              2: xfer("R4 clear", 1'b1, AW'(base + 16*i + 8), d);
              default: xfer("R5 flip", 1'b1, AW'(base + 16*i + 12), d);
            endcase
            for (int o = 0; o < 4; o++) xfer("R6 alias read", 1'b0, AW'(base + 16*i + 4*o), '0);
          end

    // R10: out-of-window writes change nothing
    xfer("R10 wr low", 1'b1, 12'h000, 32'hffff_ffff);
    xfer("R10 wr gap", 1'b1, 12'h0a0, 32'hffff_ffff);
    xfer("R10 wr gap2", 1'b1, 12'h7dc, 32'hffff_ffff);
    xfer("R10 wr high", 1'b1, 12'hffc, 32'hffff_ffff);
    readAllSlots("R10 after stray writes");

    // R11: misaligned accesses inside windows are ignored
    xfer("R11 wr", 1'b1, AW'(MB + 1), 32'h0);
    xfer("R11 wr", 1'b1, AW'(MB + 16 + 6), 32'hffff_ffff);
    xfer("R11 rd", 1'b0, AW'(AB + 3), '0);
    readAllSlots("R11 after misaligned");

    // R8 / R9: ID word is read-only and shadows the plain alias of secondary slot 2
    xfer("R8 id write", 1'b1, AW'(IDA), 32'h0);
    xfer("R8 id read", 1'b0, AW'(IDA), '0);
    xfer("R9 set via 0x804", 1'b1, AW'(IDA + 4), 32'h0000_0f00);
    xfer("R9 flip via 0x80C", 1'b1, AW'(IDA + 12), 32'h1000_0001);
    xfer("R9 read 0x808", 1'b0, AW'(IDA + 8), '0);
    xfer("R9 read 0x800", 1'b0, AW'(IDA), '0);

    // R7: back-to-back write then read of the same register
    @(negedge clk);
    busReq = 1'b1; busWrite = 1'b1; busAddr = AW'(MB + 16); busWdata = 32'h1357_9bdf;
    expMain[1] = 32'h1357_9bdf;
    @(negedge clk);
    chk("R7 b2b write ready", {31'h0, busReady}, 32'h1);
    busWrite = 1'b0; busAddr = AW'(MB + 16 + 8);
    @(negedge clk);
    busReq = 1'b0;
    chk("R7 b2b read ready", {31'h0, busReady}, 32'h1);
    chk("R7 b2b read data", busRdata, 32'h1357_9bdf);
    @(negedge clk);
    chk("R7 ready drops", {31'h0, busReady}, 32'h0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule